// File: doc/BRIEF.md
# Port-Write Capture Controller

This block takes inbound maintenance port-write packets from a serial link and keeps exactly one of them in an on-chip single-entry buffer for software to inspect. Each packet arrives as a word stream with valid, data, last and a per-beat error flag. The block always accepts a beat: `pkt_ready` is held high. There is no back-pressure, because a packet that cannot be stored is consumed and counted as dropped rather than stalled.

Software controls the block through two 32-bit registers on a simple write/read port. The mode register enables the unit, issues the clear-queue command and gates the two interrupt sources. The status register reports full, error, interrupt, discard and busy conditions. A captured message stays locked in the buffer until software releases it with clear-queue. Any packet that arrives in the meantime is thrown away and flagged. A single interrupt line combines the enabled sources.

Top module: `pw_capture_ctrl`

## Requirements
- R1: After reset, both registers read 0, `irq` is 0, `pkt_ready` is 1, and the buffer read port returns 0.
- R2: While enabled and empty, a packet of exactly 16 beats with no error flag is stored. Status bit 20 (full) and bit 4 (queue-full interrupt) are then set, and buffer index i returns the i-th beat. While the queue is not full, the buffer port returns 0.
- R3: A well-formed packet that arrives while full is dropped and sets status bit 3 (discard). The stored words are left unchanged.
- R4: Writing the mode register with bit 1 set clears full, so the next packet is accepted. Bit 1 always reads back as 0.
- R5: Writing 1 to status bit 4 or bit 3 clears that bit, and writing 0 leaves it unchanged. Writes to status bits 20 and 2 have no effect.
- R6: Writing 1 to status bit 7 (transaction error) clears it only while mode bit 0 is 0. While enabled, the bit stays set.
- R7: A packet that carries the error flag on any beat, or that is not exactly 16 beats long, sets status bit 7 and is not stored. Full is unchanged.
- R8: While mode bit 0 is 0, packets are ignored and no status bit changes.
- R9: `irq` equals (status bit 4 AND mode bit 8) OR (status bit 7 AND mode bit 5).
- R10: Mode bits 0, 5, 8 and 20 read back as written, and every other mode bit reads 0. Bit 20 (snoop) has no other effect.
- R11: Status bit 2 (busy) is 1 after the first beat of a packet of two or more beats, and returns to 0 after its last beat.
- R12: Register address 0 selects the mode register and address 1 selects the status register. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Beat valid |
| pkt_ready | output | 1 | Beat accepted (always 1) |
| pkt_data | input | 32 | Beat payload word |
| pkt_last | input | 1 | Final beat of packet |
| pkt_err | input | 1 | Link reported an error on this beat |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| buf_rd_idx | input | 4 | Word index into captured message |
| buf_rd_data | output | 32 | Captured word, 0 when not full |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the locked queue. A second packet that overwrote the buffer would show changed words, and a packet missing the discard flag would leave bit 3 clear. It checks that an error clear attempted while enabled is refused, which a design that cleared unconditionally would fail. It sends short, long and error-flagged packets: a design that stored them would raise full, and one that failed to flag them would leave bit 7 clear. It also sends traffic while the unit is disabled, where any status movement shows that the enable gate was skipped.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // mode register field positions
  localparam int MODE_EN  = 0;
  localparam int MODE_CQ  = 1;
  localparam int MODE_EIE = 5;
  localparam int MODE_QIE = 8;
  localparam int MODE_SNP = 20;
  // status register field positions
  localparam int ST_BUSY = 2;
  localparam int ST_PWD  = 3;
  localparam int ST_QFI  = 4;
  localparam int ST_TE   = 7;
  localparam int ST_FULL = 20;

  typedef struct packed {
    logic commit;
    logic bad;
    logic drop;
  } pw_event_t;
endpackage

// File: rtl/pw_rx_assembler.sv
module pw_rx_assembler
  import pw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  localparam int IDX_W = $clog2(MSG_WORDS),
  localparam int CNT_W = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              buf_full,
  input  logic              pkt_valid,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  input  logic              pkt_err,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output pw_event_t         ev,
  output logic              busy
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MSG_WORDS - 1);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(MSG_WORDS);

  logic [CNT_W-1:0] cnt_q;
  logic             err_seen_q, blk_seen_q;
  logic             beat, end_beat, bad_now, blk_now;

  always_comb begin
    beat     = enable & pkt_valid;
    end_beat = beat & pkt_last;
    wr_en    = beat & ~buf_full & (cnt_q < SAT_CNT);
    wr_idx   = cnt_q[IDX_W-1:0];
    wr_data  = pkt_data;
    bad_now  = err_seen_q | pkt_err | (cnt_q != LAST_CNT);
    blk_now  = blk_seen_q | buf_full;
    ev.bad    = end_beat & bad_now;
    ev.drop   = end_beat & ~bad_now & blk_now;
    ev.commit = end_beat & ~bad_now & ~blk_now;
    busy     = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      err_seen_q <= 1'b0;
      blk_seen_q <= 1'b0;
    end else if (!enable) begin
      cnt_q      <= '0;
      err_seen_q <= 1'b0;
      blk_seen_q <= 1'b0;
    end else if (beat) begin
      if (pkt_last) begin
        cnt_q      <= '0;
        err_seen_q <= 1'b0;
        blk_seen_q <= 1'b0;
      end else begin
        cnt_q      <= (cnt_q == SAT_CNT) ? cnt_q : cnt_q + 1'b1;
        err_seen_q <= err_seen_q | pkt_err;
        blk_seen_q <= blk_seen_q | buf_full;
      end
    end
  end

  // a non-final beat leaves the unit busy in the next cycle
  p_busy_mid_packet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !pkt_last) |=> busy);
  // a final beat always returns the unit to idle
  p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    end_beat |=> !busy);
endmodule

// File: rtl/pw_msg_buffer.sv
module pw_msg_buffer #(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  localparam int IDX_W = $clog2(MSG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [MSG_WORDS];

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        mem[g] <= wr_data;
    end
  end

  assign rd_data = full ? mem[rd_idx] : '0;

  // the stored entry is locked while full: no word may be written
  p_no_write_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // nothing visible while empty
  p_empty_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> (rd_data == '0));
endmodule

// File: rtl/pw_csr.sv
module pw_csr
  import pw_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  pw_event_t        ev,
  input  logic             busy,
  output logic             mode_en,
  output logic             full,
  output logic             irq
);
  logic en_q, eie_q, qie_q, snp_q;
  logic full_q, te_q, qfi_q, pwd_q;
  logic wr_mode, wr_stat;
  logic unused_wdata;

  assign wr_mode      = reg_wr_en & (reg_addr == 1'b0);
  assign wr_stat      = reg_wr_en & (reg_addr == 1'b1);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      eie_q <= 1'b0;
      qie_q <= 1'b0;
      snp_q <= 1'b0;
    end else if (wr_mode) begin
      en_q  <= reg_wdata[MODE_EN];
      eie_q <= reg_wdata[MODE_EIE];
      qie_q <= reg_wdata[MODE_QIE];
      snp_q <= reg_wdata[MODE_SNP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      te_q   <= 1'b0;
      qfi_q  <= 1'b0;
      pwd_q  <= 1'b0;
    end else begin
      if (ev.commit)                                full_q <= 1'b1;
      else if (wr_mode && reg_wdata[MODE_CQ])       full_q <= 1'b0;
      if (ev.commit)                                qfi_q  <= 1'b1;
      else if (wr_stat && reg_wdata[ST_QFI])        qfi_q  <= 1'b0;
      if (ev.drop)                                  pwd_q  <= 1'b1;
      else if (wr_stat && reg_wdata[ST_PWD])        pwd_q  <= 1'b0;
      if (ev.bad)                                   te_q   <= 1'b1;
      else if (wr_stat && reg_wdata[ST_TE] && !en_q) te_q  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 1'b0) begin
      reg_rdata[MODE_EN]  = en_q;
      reg_rdata[MODE_EIE] = eie_q;
      reg_rdata[MODE_QIE] = qie_q;
      reg_rdata[MODE_SNP] = snp_q;
    end else begin
      reg_rdata[ST_FULL] = full_q;
      reg_rdata[ST_TE]   = te_q;
      reg_rdata[ST_QFI]  = qfi_q;
      reg_rdata[ST_PWD]  = pwd_q;
      reg_rdata[ST_BUSY] = busy;
    end
  end

  assign mode_en = en_q;
  assign full    = full_q;
  assign irq     = (qfi_q & qie_q) | (te_q & eie_q);

  // error bit cannot be cleared while the unit runs
  p_te_kept_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (te_q && en_q) |=> te_q);
  // only the clear-queue command releases the entry
  p_full_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !(wr_mode && reg_wdata[MODE_CQ])) |=> full_q);
  // disabled and untouched by software: status frozen
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr_en) |=> $stable({full_q, te_q, qfi_q, pwd_q}));
  // capture raises the queue-full interrupt together with full
  p_capture_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> qfi_q);
endmodule

// File: rtl/pw_capture_ctrl.sv
module pw_capture_ctrl
  import pw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  localparam int IDX_W = $clog2(MSG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  input  logic              pkt_err,
  input  logic              reg_wr_en,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  buf_rd_idx,
  output logic [DATA_W-1:0] buf_rd_data,
  output logic              irq
);
  logic              mode_en, full, busy, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  pw_event_t         ev;

  assign pkt_ready = 1'b1;

  pw_rx_assembler #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_asm (
    .clk(clk), .rst_n(rst_n), .enable(mode_en), .buf_full(full),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .pkt_err(pkt_err), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ev(ev), .busy(busy)
  );

  pw_msg_buffer #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .full(full), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(buf_rd_idx), .rd_data(buf_rd_data)
  );

  pw_csr #(.REG_W(32)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev(ev), .busy(busy),
    .mode_en(mode_en), .full(full), .irq(irq)
  );

  // R9: the interrupt tracks its enabled sources
  p_irq_sources_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((reg_addr == 1'b1) ? (reg_rdata[ST_QFI] || reg_rdata[ST_TE]) : 1'b1));
endmodule

// File: tb/pw_capture_ctrl_tb.sv
`timescale 1ns/1ps
module pw_capture_ctrl_tb;
  localparam int W = 16;
  localparam logic [31:0] MODE_MASK = 32'h0010_0121;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0, pkt_last = 1'b0, pkt_err = 1'b0;
  logic        pkt_ready;
  logic [31:0] pkt_data = '0;
  logic        reg_wr_en = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  buf_rd_idx = '0;
  logic [31:0] buf_rd_data;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [31:0] m_mode = '0;
  logic m_full = 0, m_te = 0, m_qfi = 0, m_pwd = 0;
  logic [31:0] m_mem [W];

  always #2.5 clk = ~clk;

  pw_capture_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_err(pkt_err),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .irq(irq)
  );

  function automatic logic [31:0] exp_status();
    return (32'(m_full) << 20) | (32'(m_te) << 7) | (32'(m_qfi) << 4) | (32'(m_pwd) << 3);
  endfunction

  function automatic logic exp_irq();
    return (m_qfi & m_mode[8]) | (m_te & m_mode[5]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    reg_addr = 1'b1; #0.2;
    chk({tag, " status R2 R3 R5 R6 R7 R8"}, reg_rdata, exp_status());
    reg_addr = 1'b0; #0.2;
    chk({tag, " mode R10 R12"}, reg_rdata, m_mode);
    chk({tag, " irq R9"}, 32'(irq), 32'(exp_irq()));
    for (int i = 0; i < W; i++) begin
      buf_rd_idx = 4'(i); #0.1;
      chk({tag, " buffer R2 R3"}, buf_rd_data, m_full ? m_mem[i] : 32'h0);
    end
    @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
    if (a == 1'b0) begin
      if (d[1]) m_full = 0;
      m_mode = d & MODE_MASK;
    end else begin
      if (d[4]) m_qfi = 0;
      if (d[3]) m_pwd = 0;
      if (d[7] && !m_mode[0]) m_te = 0;
    end
  endtask

  task automatic send_pkt(int len, int err_beat);
    logic [31:0] words [W];
    logic bad;
    reg_addr = 1'b1;
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (i < W) words[i] = d;
      pkt_valid = 1'b1; pkt_data = d;
      pkt_last = (i == len - 1); pkt_err = (i == err_beat);
      tick();
      if (i == 0 && len > 1 && m_mode[0]) begin
        reg_addr = 1'b1; #0.2;
        chk("busy during packet R11", 32'(reg_rdata[2]), 32'd1);
      end
    end
    pkt_valid = 1'b0; pkt_last = 1'b0; pkt_err = 1'b0;
    reg_addr = 1'b1; #0.2;
    chk("busy after packet R11", 32'(reg_rdata[2]), 32'd0);
    bad = (len != W) || (err_beat >= 0 && err_beat < len);
    if (m_mode[0]) begin
      if (bad) m_te = 1;
      else if (m_full) m_pwd = 1;
      else begin
        m_full = 1; m_qfi = 1;
        for (int i = 0; i < W; i++) m_mem[i] = words[i];
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < W; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("ready R1", 32'(pkt_ready), 32'd1);
    check_all("reset R1");

    // R10: bit 1 and stray bits read 0
    wr_reg(1'b0, 32'hFFFF_FFFF & ~32'h1);
    check_all("mode readback R10");
    wr_reg(1'b0, 32'h0010_0121);
    check_all("enable R10");

    // R2 capture
    send_pkt(W, -1);
    check_all("capture R2 R9");

    // R3 locked entry
    send_pkt(W, -1);
    check_all("discard while full R3");

    // R5 write zero, then bits 20 and 2 ignored, then W1C
    wr_reg(1'b1, 32'h0);
    check_all("status write zero R5");
    wr_reg(1'b1, 32'h0010_0004);
    check_all("status ro bits R5");
    wr_reg(1'b1, 32'h0000_0018);
    check_all("status w1c R5");

    // R4 clear queue, then next packet accepted
    wr_reg(1'b0, 32'h0000_0123);
    check_all("clear queue R4");
    send_pkt(W, -1);
    check_all("capture after clear R4");
    wr_reg(1'b0, 32'h0000_0123);

    // R7 error flag, short, long
    send_pkt(W, 5);
    check_all("err flag R7");
    send_pkt(3, -1);
    check_all("short packet R7");
    send_pkt(W + 3, -1);
    check_all("long packet R7");

    // R6 clear while enabled refused, then while disabled accepted
    wr_reg(1'b1, 32'h80);
    check_all("te clear enabled R6");
    wr_reg(1'b0, 32'h0000_0020);
    wr_reg(1'b1, 32'h80);
    check_all("te clear disabled R6");

    // R8 disabled traffic ignored
    send_pkt(W, -1);
    check_all("disabled good R8");
    send_pkt(4, 1);
    check_all("disabled bad R8");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) begin
        int len, eb;
        len = ($urandom % 3 != 0) ? W : 1 + ($urandom % 20);
        eb  = ($urandom % 5 == 0) ? int'($urandom % 20) : -1;
        send_pkt(len, eb);
      end else if (r < 7) begin
        wr_reg(1'b1, $urandom & 32'h0010_009C);
      end else if (r < 9) begin
        logic [31:0] m;
        m = $urandom & 32'h0010_0123;
        if ($urandom % 4 != 0) m[0] = 1'b1;
        wr_reg(1'b0, m);
      end
      check_all("random R2 R3 R4 R5 R6 R7 R8 R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule